// File: doc/BRIEF.md
# Asynchronous Static Memory Access Sequencer

This block is a synchronous controller that runs one access at a time on an asynchronous static memory. The memory has an active-low chip select, an active-low write enable and an active-low output enable. A requester presents a read or write request, an address, write data and four wait lengths: setup, hold, read access and write time. The controller places the address on the memory bus, and for writes also the data. It then steps the strobes through a fixed order. The enable strobe (output enable for reads, write enable for writes) falls first and chip select falls after it. At the end chip select rises first and the enable rises after it.

Every wait is a cycle count N taken at the request interface, and it lasts N+1 clock cycles, so a count of zero still gives one cycle. A read samples the memory's returned word in the last access cycle and keeps that word on `rd_data` until a later read replaces it. The controller drives the data bus only for a write, and it signals completion with a one-cycle `done` pulse. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `sram_seq`

## Requirements
- R1: While reset is applied and just after it, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are all 1, `mem_dq_oe` is 0, `done` is 0 and `rd_data` is 0.
- R2: Read order. Take the first cycle after the accepting edge as cycle 1 and write S, H, A for the setup, hold and read-access counts. `mem_oe_n` first goes low in cycle S+2. `mem_cs_n` first goes low in cycle S+H+3 and stays low for A+1 cycles. `mem_we_n` stays 1 throughout. Chip select is never low unless an enable strobe is low.
- R3: Write order. The same cycle numbers as R2 apply, using `mem_we_n` in place of `mem_oe_n` and the write-time count W in place of A. `mem_oe_n` stays 1 throughout. The two enable strobes are never low together.
- R4: Release order. `mem_cs_n` returns to 1 in cycle S+H+A+4 (S+H+W+4 for a write), one cycle before the enable strobe returns to 1 in cycle S+H+A+5 (S+H+W+5).
- R5: `done` is 1 for exactly one cycle per access. That cycle is the first one in which all three strobes are high again (cycle S+H+A+5 or S+H+W+5).
- R6: A read loads `rd_data` with the value of `mem_dq_in` sampled in its last chip-select-low cycle. `rd_data` then keeps that value through idle time and through write accesses.
- R7: `mem_dq_oe` is 1 only during a write, from cycle 1 through the chip-select release cycle, and there `mem_dq_out` equals the write data. For reads it stays 0, so the bus is never driven while `mem_oe_n` is low.
- R8: A wait count of 0 lasts one cycle and a count of N lasts N+1 cycles. The read-access count `rd_cyc` is used only for reads and the write-time count `wr_cyc` only for writes.
- R9: A request is accepted only when the controller is idle. Requests raised during an access are ignored and start no new access. Address, data, direction and all wait counts are latched at acceptance, so later input changes have no effect on the running access.
- R10: `mem_addr` holds the latched request address from cycle 1 until the access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| setup_cyc | input | CNT_W | Address setup wait count |
| hold_cyc | input | CNT_W | Hold wait count between enable and chip select |
| rd_cyc | input | CNT_W | Read access wait count |
| wr_cyc | input | CNT_W | Write time wait count |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Last word captured by a read |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_out | output | DATA_W | Data driven to the memory |
| mem_dq_oe | output | 1 | Data bus drive enable (1 = driving) |
| mem_dq_in | input | DATA_W | Data returned by the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
All results are timed from the cycle after the accepting edge. The enable falls at S+2, chip select falls at S+H+3, chip select rises at S+H+A+4, and the enable rises together with `done` at S+H+A+5. `rd_data` is valid from the chip-select release cycle onward. The bench drives and samples on the falling clock edge. For each access it logs the first cycle in which every strobe, `done` and the bus enable change, and compares those cycle numbers with the ones computed from the wait counts in the table. It also counts the cycles chip select stays low and checks the bus and address in every cycle.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_ENA   = 3'd2,
    ST_ACC   = 3'd3,
    ST_RCS   = 3'd4,
    ST_FIN   = 3'd5
  } seq_state_e;
endpackage

// File: rtl/sram_seq_phase_cnt.sv
module sram_seq_phase_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [CNT_W-1:0] setup_cyc,
  input  logic [CNT_W-1:0] hold_cyc,
  input  logic [CNT_W-1:0] rd_cyc,
  input  logic [CNT_W-1:0] wr_cyc,
  input  logic             expired,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             accept,
  output logic             is_write,
  output seq_state_e       state
);
  seq_state_e       state_d;
  logic [CNT_W-1:0] hold_q, acc_q;
  logic             wr_q;

  assign accept = (state == ST_IDLE) && req_valid;

  always_comb begin
    state_d  = state;
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (state)
      ST_IDLE: if (req_valid) begin
        state_d  = ST_SETUP;
        cnt_load = 1'b1;
        cnt_val  = setup_cyc;
      end
      ST_SETUP: if (expired) begin
        state_d  = ST_ENA;
        cnt_load = 1'b1;
        cnt_val  = hold_q;
      end
      ST_ENA: if (expired) begin
        state_d  = ST_ACC;
        cnt_load = 1'b1;
        cnt_val  = acc_q;
      end
      ST_ACC:  if (expired) state_d = ST_RCS;
      ST_RCS:  state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      acc_q  <= '0;
      wr_q   <= 1'b0;
    end else if (accept) begin
      hold_q <= hold_cyc;
      acc_q  <= req_write ? wr_cyc : rd_cyc;
      wr_q   <= req_write;
    end
  end

  assign is_write = wr_q;
endmodule

// File: rtl/sram_seq_strobe.sv
module sram_seq_strobe
  import sram_seq_pkg::*;
(
  input  seq_state_e state,
  input  logic       is_write,
  input  logic       expired,
  output logic       cs_n,
  output logic       we_n,
  output logic       oe_n,
  output logic       bus_drive,
  output logic       capture,
  output logic       done
);
  logic en_on;

  always_comb begin
    en_on     = (state == ST_ENA) || (state == ST_ACC) || (state == ST_RCS);
    cs_n      = !(state == ST_ACC);
    we_n      = !(en_on && is_write);
    oe_n      = !(en_on && !is_write);
    bus_drive = is_write && (state != ST_IDLE) && (state != ST_FIN);
    capture   = (state == ST_ACC) && expired && !is_write;
    done      = (state == ST_FIN);
  end
endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [CNT_W-1:0]  setup_cyc,
  input  logic [CNT_W-1:0]  hold_cyc,
  input  logic [CNT_W-1:0]  rd_cyc,
  input  logic [CNT_W-1:0]  wr_cyc,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  seq_state_e       state;
  logic             expired, cnt_load, accept, is_write, capture, bus_drive;
  logic [CNT_W-1:0] cnt_val;
  logic             cs_raw, we_raw, oe_raw;

  sram_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .setup_cyc (setup_cyc),
    .hold_cyc  (hold_cyc),
    .rd_cyc    (rd_cyc),
    .wr_cyc    (wr_cyc),
    .expired   (expired),
    .cnt_load  (cnt_load),
    .cnt_val   (cnt_val),
    .accept    (accept),
    .is_write  (is_write),
    .state     (state)
  );

  sram_seq_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .expired  (expired)
  );

  sram_seq_strobe u_strobe (
    .state     (state),
    .is_write  (is_write),
    .expired   (expired),
    .cs_n      (cs_raw),
    .we_n      (we_raw),
    .oe_n      (oe_raw),
    .bus_drive (bus_drive),
    .capture   (capture),
    .done      (done)
  );

  // Strobes are forced inactive the moment reset is applied.
  assign mem_cs_n  = cs_raw | ~rst_int_n;
  assign mem_we_n  = we_raw | ~rst_int_n;
  assign mem_oe_n  = oe_raw | ~rst_int_n;
  assign mem_dq_oe = bus_drive & rst_int_n;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   rdata_q <= '0;
    else if (capture) rdata_q <= mem_dq_in;
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign rd_data    = rdata_q;
endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic [DATA_W-1:0] rd_data,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n
);
  assert_cs_after_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> (!mem_oe_n || !mem_we_n));

  assert_en_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  assert_cs_first_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) |-> (!mem_oe_n || !mem_we_n));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_cs_n && mem_oe_n && mem_we_n));

  assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(mem_cs_n) |-> $stable(rd_data));

  assert_bus_safe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
endmodule

bind sram_seq sram_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .rd_data   (rd_data),
  .mem_addr  (mem_addr),
  .mem_dq_oe (mem_dq_oe),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n)
);

// File: tb/sram_seq_tb.sv
module sram_seq_tb;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [CW-1:0] setup_cyc = '0, hold_cyc = '0, rd_cyc = '0, wr_cyc = '0;
  logic          done, mem_dq_oe, mem_cs_n, mem_we_n, mem_oe_n;
  logic [DW-1:0] rd_data, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;

  int checks = 0, failures = 0;
  logic [DW-1:0] mem [16];

  always #4 clk = ~clk;

  sram_seq #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .setup_cyc(setup_cyc),
    .hold_cyc(hold_cyc), .rd_cyc(rd_cyc), .wr_cyc(wr_cyc), .done(done),
    .rd_data(rd_data), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .mem_cs_n(mem_cs_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n));

  // Memory model: stores while cs and we are low, returns data while cs and oe are low.
  always @(posedge clk)
    if (!mem_cs_n && !mem_we_n && mem_dq_oe) mem[mem_addr[3:0]] <= mem_dq_out;
  assign mem_dq_in = (!mem_cs_n && !mem_oe_n) ? mem[mem_addr[3:0]] : 16'hDEAD;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [CW-1:0] s, h, a;
    logic [DW-1:0] exp;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'h0003, 16'hA5A5, 8'd0, 8'd0, 8'd0, 16'h0000},
    '{1'b0, 16'h0003, 16'h0000, 8'd0, 8'd0, 8'd0, 16'hA5A5},
    '{1'b1, 16'h0007, 16'h1234, 8'd2, 8'd1, 8'd3, 16'h0000},
    '{1'b0, 16'h0007, 16'h0000, 8'd1, 8'd2, 8'd4, 16'h1234},
    '{1'b1, 16'h0003, 16'h0FF0, 8'd3, 8'd0, 8'd1, 16'h0000},
    '{1'b0, 16'h0003, 16'h0000, 8'd0, 8'd3, 8'd0, 16'h0FF0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input vec_t v, input bit poke, input logic [DW-1:0] prev_rd);
    int t_en = -1, t_csl = -1, t_csh = -1, t_enh = -1, t_done = -1;
    int n_done = 0, n_cs = 0, bad_other = 0, bad_addr = 0, bad_bus = 0;
    int tt;
    bit en, oth, exp_oe;
    tt = int'(v.s) + int'(v.h) + int'(v.a);
    @(negedge clk);
    req_valid = 1'b1; req_write = v.wr; req_addr = v.addr; req_wdata = v.data;
    setup_cyc = v.s; hold_cyc = v.h;
    rd_cyc = v.wr ? v.a + 8'd5 : v.a;
    wr_cyc = v.wr ? v.a : v.a + 8'd5;
    for (int t = 1; t <= tt + 8; t++) begin
      @(negedge clk);
      if (t == 1) begin
        // R9: inputs change after acceptance
        req_valid = 1'b0; req_addr = 16'hFFFF; req_wdata = 16'h5555;
        setup_cyc = 8'd9; hold_cyc = 8'd9; rd_cyc = 8'd9; wr_cyc = 8'd9;
        req_write = ~v.wr;
      end
      if (poke && t == 2) req_valid = 1'b1;
      if (poke && t == 3) req_valid = 1'b0;
      en  = v.wr ? mem_we_n : mem_oe_n;
      oth = v.wr ? mem_oe_n : mem_we_n;
      if (!en && t_en < 0) t_en = t;
      if (!mem_cs_n) begin n_cs++; if (t_csl < 0) t_csl = t; end
      if (mem_cs_n && t_csl >= 0 && t_csh < 0) t_csh = t;
      if (en && t_en >= 0 && t_enh < 0) t_enh = t;
      if (done) begin n_done++; t_done = t; end
      if (!oth) bad_other++;
      if (t <= tt + 5 && mem_addr != v.addr) bad_addr++;
      exp_oe = v.wr && (t <= tt + 4);
      if (mem_dq_oe != exp_oe || (exp_oe && mem_dq_out != v.data)) bad_bus++;
    end
    if (v.wr) begin
      chk(t_en == int'(v.s) + 2, "R3 we_n fall cycle", t_en, int'(v.s) + 2);
      chk(t_csl == int'(v.s) + int'(v.h) + 3, "R3 cs_n fall cycle", t_csl, int'(v.s) + int'(v.h) + 3);
      chk(bad_other == 0, "R3 oe_n stays high", bad_other, 0);
      chk(rd_data == prev_rd, "R6 rd_data held over write", int'(rd_data), int'(prev_rd));
    end else begin
      chk(t_en == int'(v.s) + 2, "R2 oe_n fall cycle", t_en, int'(v.s) + 2);
      chk(t_csl == int'(v.s) + int'(v.h) + 3, "R2 cs_n fall cycle", t_csl, int'(v.s) + int'(v.h) + 3);
      chk(bad_other == 0, "R2 we_n stays high", bad_other, 0);
      chk(rd_data == v.exp, "R6 read data", int'(rd_data), int'(v.exp));
    end
    chk(n_cs == int'(v.a) + 1, "R8 access length", n_cs, int'(v.a) + 1);
    chk(t_csh == tt + 4, "R4 cs_n rise cycle", t_csh, tt + 4);
    chk(t_enh == tt + 5, "R4 enable rise cycle", t_enh, tt + 5);
    chk(n_done == 1 && t_done == tt + 5, "R5 done pulse", t_done, tt + 5);
    chk(bad_bus == 0, "R7 bus drive", bad_bus, 0);
    chk(bad_addr == 0, "R10 address held", bad_addr, 0);
  endtask

  initial begin
    logic [DW-1:0] last_rd;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes in reset", {mem_cs_n, mem_we_n, mem_oe_n}, 7);
    chk(!mem_dq_oe && !done, "R1 bus and done in reset", {mem_dq_oe, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(mem_cs_n && mem_we_n && mem_oe_n && !done, "R1 idle after reset",
        {mem_cs_n, mem_we_n, mem_oe_n, done}, 14);
    chk(rd_data == '0, "R1 rd_data reset", int'(rd_data), 0);

    last_rd = '0;
    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i], 1'b0, last_rd);
      if (!VEC[i].wr) last_rd = VEC[i].exp;
    end

    // R9: request raised during a busy access is ignored
    run_op(VEC[2], 1'b1, last_rd);
    repeat (3) @(negedge clk);
    chk(mem_cs_n && mem_we_n && mem_oe_n, "R9 no extra access", {mem_cs_n, mem_we_n, mem_oe_n}, 7);

    // R1: reset applied in the middle of a write
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0005; req_wdata = 16'h7777;
    setup_cyc = 8'd0; hold_cyc = 8'd4; wr_cyc = 8'd2; rd_cyc = 8'd2;
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
    chk(!mem_we_n, "R3 we_n low before reset", mem_we_n, 0);
    #1 rst_n = 1'b0;
    #1 chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 async reset mid access",
           {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 14);
    chk(rd_data == '0, "R1 rd_data cleared", int'(rd_data), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_op(VEC[5], 1'b0, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule